// File: doc/BRIEF.md
# Working-Set Stream Queue

This block is a hardware queue between one producer thread and one consumer thread. Its storage is cut into equal slots, called working sets. The producer fills one slot at a time through a private write offset. The consumer drains one slot at a time through a private read offset. The two shared slot counters, head and tail, move only when a whole slot is completed or emptied. Because of this, the shared state is touched once per slot rather than once per word.

Each shared counter is stored as a SECDED Hamming codeword. A single flipped bit is repaired without any visible effect. A double flip flushes the queue to empty and raises a sticky error flag. The codeword is decoded again only after something other than the block's own write has changed it, so a request that is spinning on a full or empty queue does not repeat the check. Fault masks on two input ports XOR into the stored codewords to model upsets.

Every word carries a tag bit, and the consumer side returns that tag beside the payload. A push waits while the queue is full and a pop waits while it is empty. After a fixed number of blocked cycles, either request is released anyway and a sticky timeout flag is set. A discard request takes the head word and returns it without ever waiting.

Top module: `wsq_stream_queue`

## Requirements
- R1: After reset the queue reports empty and not full, both sticky flags are low, and no acknowledge is raised without a request.
- R2: Words become visible to the consumer only in whole slots of DEPTH words. A slot holding fewer than DEPTH pushed words cannot be popped.
- R3: Words come out in push order. Each pop returns the pushed payload and its tag (1 = header, 0 = item).
- R4: With SLOTS complete slots unreleased, the queue reports full. Filling up to that point never makes a push wait.
- R5: A push blocked for TIMEOUT consecutive cycles is acknowledged in the next evaluated cycle without storing its word, and the sticky timeout flag rises.
- R6: A pop blocked for TIMEOUT consecutive cycles is acknowledged with payload 0 and tag 0, and the sticky timeout flag rises.
- R7: A discard never waits. It removes the head word and returns it, or returns 0 when the queue is empty. While a pop is requested in the same cycle, the discard is not served.
- R8: A single-bit fault in either shared counter codeword is corrected. The error flag stays low and the queue contents are unchanged.
- R9: A double-bit fault in a shared counter codeword sets the sticky error flag and empties the queue. Afterwards the queue works normally from empty.
- R10: A push that completes a slot and a pop that empties a slot may be accepted in the same cycle. Both shared counters advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Producer push request, held until acknowledged |
| push_data | input | DATA_W | Push payload |
| push_tag | input | 1 | Push tag, 1 = header |
| push_ack | output | 1 | Push completed this cycle |
| pop_req | input | 1 | Consumer pop request, held until acknowledged |
| disc_req | input | 1 | Discard request for the head word |
| pop_ack | output | 1 | Pop completed this cycle |
| disc_ack | output | 1 | Discard completed this cycle |
| rd_data | output | DATA_W | Payload of the word taken this cycle, else 0 |
| rd_tag | output | 1 | Tag of the word taken this cycle, else 0 |
| q_full | output | 1 | All slots published and unreleased |
| q_empty | output | 1 | No published slot to read |
| timeout_flag | output | 1 | Sticky: a blocked request was released by timeout |
| ecc_err | output | 1 | Sticky: an uncorrectable shared counter fault flushed the queue |
| fault_head | input | CW | XOR mask applied to the stored head codeword |
| fault_tail | input | CW | XOR mask applied to the stored tail codeword |

## Verification
The delicate overlap is a cycle in which the producer's last word of a slot publishes the tail while the consumer's last word of another slot releases the head. Each side changes one shared codeword, and both results feed the full and empty terms. The bench sets this up by filling one slot plus three words, then draining three words. Next it raises the push and the pop on the same edge. It requires both acknowledges, the correct head word, a non-empty queue afterwards and the second slot's words in order. A second overlap, pop against discard, is raised together and judged by which acknowledge appears first.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  typedef enum logic {
    WORD_ITEM = 1'b0,
    WORD_HDR  = 1'b1
  } wtag_e;

  // total codeword length of a SECDED Hamming code over dw data bits
  function automatic int ham_len(input int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return dw + p + 1;
  endfunction

endpackage

// File: rtl/wsq_ecc_ptr.sv
module wsq_ecc_ptr import wsq_pkg::*; #(
  parameter  int PW = 4,
  localparam int CW = ham_len(PW),
  localparam int SW = $clog2(CW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_val,
  input  logic [CW-1:0] flt,
  output logic [PW-1:0] val,
  output logic          dbl
);

  function automatic logic [CW-1:0] enc(input logic [PW-1:0] v);
    logic [CW-1:0] c;
    logic b;
    int j;
    c = '0;
    j = 0;
    for (int pos = 1; pos < CW; pos++)
      if ((pos & (pos - 1)) != 0) begin
        c[pos] = v[j];
        j++;
      end
    for (int p = 0; (1 << p) < CW; p++) begin
      b = 1'b0;
      for (int pos = 1; pos < CW; pos++)
        if ((pos & (1 << p)) != 0) b = b ^ c[pos];
      c[1 << p] = b;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  // returns {double, corrected, value}
  function automatic logic [PW+1:0] dec(input logic [CW-1:0] code_in);
    logic [CW-1:0] c;
    logic [SW-1:0] syn;
    logic          par;
    logic [PW-1:0] v;
    int j;
    c   = code_in;
    syn = '0;
    par = 1'b0;
    for (int pos = 0; pos < CW; pos++)
      if (c[pos]) begin
        par = ~par;
        syn = syn ^ SW'(pos);
      end
    if (par && syn != '0 && int'(syn) < CW) c[syn] = ~c[syn];
    v = '0;
    j = 0;
    for (int pos = 1; pos < CW; pos++)
      if ((pos & (pos - 1)) != 0) begin
        v[j] = c[pos];
        j++;
      end
    return {(!par && syn != '0), par, v};
  endfunction

  logic [CW-1:0] code;
  logic          dirty;   // stored word altered by a fault since last check
  logic          chk;     // decode result is consumed this cycle
  logic [PW-1:0] d_val;
  logic          d_fix, d_dbl;

  assign {d_dbl, d_fix, d_val} = dec(code);
  assign chk = dirty;
  assign dbl = chk && d_dbl;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      code  <= enc('0);
      val   <= '0;
      dirty <= 1'b0;
    end else if (wr_en) begin
      code  <= enc(wr_val) ^ flt;
      val   <= wr_val;
      dirty <= |flt;
    end else if (dirty) begin
      code  <= enc(d_val) ^ flt;
      val   <= d_val;
      dirty <= |flt;
    end else begin
      code  <= code ^ flt;
      dirty <= |flt;
    end
  end

  // R8: a check only runs after a fault touched the stored word, never while idle-spinning
  p_check_after_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk |-> $past(|flt));

  // R8: a single-bit repair leaves the pointer value unchanged
  p_fix_keeps_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && d_fix && !wr_en && !clr) |=> (val == $past(val)));

endmodule

// File: rtl/wsq_wait_timer.sv
module wsq_wait_timer #(
  parameter  int LIMIT = 20,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ok,
  output logic expired
);

  logic [CNT_W-1:0] cnt;

  assign expired = req && !ok && (cnt == CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (req && !ok && !expired) cnt <= cnt + 1'b1;
    else cnt <= '0;
  end

  // R5: release only ends a request that was blocked the cycle before
  p_release_after_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(req && !ok));

endmodule

// File: rtl/wsq_store.sv
module wsq_store #(
  parameter int WW = 17,
  parameter int AW = 5,
  localparam int N = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);

  logic [WW-1:0] mem [N];

  always_ff @(posedge clk)
    if (we) mem[waddr] <= wdata;

  assign rdata = mem[raddr];

endmodule

// File: rtl/wsq_stream_queue.sv
module wsq_stream_queue import wsq_pkg::*; #(
  parameter  int DATA_W  = 16,
  parameter  int SLOTS   = 8,
  parameter  int DEPTH   = 4,
  parameter  int TIMEOUT = 20,
  localparam int PTR_W   = $clog2(SLOTS) + 1,
  localparam int CW      = ham_len(PTR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_tag,
  output logic              push_ack,
  input  logic              pop_req,
  input  logic              disc_req,
  output logic              pop_ack,
  output logic              disc_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic              q_full,
  output logic              q_empty,
  output logic              timeout_flag,
  output logic              ecc_err,
  input  logic [CW-1:0]     fault_head,
  input  logic [CW-1:0]     fault_tail
);

  localparam int OFF_W = $clog2(DEPTH);
  localparam int AW    = PTR_W - 1 + OFF_W;
  localparam int WW    = DATA_W + 1;

  logic [PTR_W-1:0] hd_v, tl_v, used;
  logic [OFF_W-1:0] wr_off, rd_off;
  logic             hd_dbl, tl_dbl, flush;
  logic             push_ok, pop_ok, push_to, pop_to;
  logic             push_wr, pop_rd, disc_rd, take, pub, rel;
  logic [WW-1:0]    rd_word;

  assign flush   = hd_dbl | tl_dbl;
  assign used    = tl_v - hd_v;
  assign q_full  = (used == PTR_W'(SLOTS));
  assign q_empty = (used == '0);

  assign push_ok  = !q_full && !flush;
  assign pop_ok   = !q_empty && !flush;
  assign push_wr  = push_req && push_ok;
  assign push_ack = push_req && (push_ok || push_to);
  assign pop_rd   = pop_req && pop_ok;
  assign pop_ack  = pop_req && (pop_ok || pop_to);
  assign disc_ack = disc_req && !pop_req;
  assign disc_rd  = disc_ack && pop_ok;
  assign take     = pop_rd || disc_rd;
  assign pub      = push_wr && (wr_off == OFF_W'(DEPTH - 1));
  assign rel      = take && (rd_off == OFF_W'(DEPTH - 1));

  assign rd_data = take ? rd_word[DATA_W-1:0] : '0;
  assign rd_tag  = take ? rd_word[DATA_W]     : logic'(WORD_ITEM);

  wsq_ecc_ptr #(.PW(PTR_W)) u_head (
    .clk(clk), .rst_n(rst_n), .clr(flush), .wr_en(rel),
    .wr_val(hd_v + 1'b1), .flt(fault_head), .val(hd_v), .dbl(hd_dbl));

  wsq_ecc_ptr #(.PW(PTR_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .clr(flush), .wr_en(pub),
    .wr_val(tl_v + 1'b1), .flt(fault_tail), .val(tl_v), .dbl(tl_dbl));

  wsq_wait_timer #(.LIMIT(TIMEOUT)) u_push_wait (
    .clk(clk), .rst_n(rst_n), .req(push_req), .ok(push_ok), .expired(push_to));

  wsq_wait_timer #(.LIMIT(TIMEOUT)) u_pop_wait (
    .clk(clk), .rst_n(rst_n), .req(pop_req), .ok(pop_ok), .expired(pop_to));

  wsq_store #(.WW(WW), .AW(AW)) u_store (
    .clk(clk), .we(push_wr),
    .waddr({tl_v[PTR_W-2:0], wr_off}), .wdata({push_tag, push_data}),
    .raddr({hd_v[PTR_W-2:0], rd_off}), .rdata(rd_word));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_off <= '0;
      rd_off <= '0;
    end else begin
      if (push_wr) wr_off <= wr_off + 1'b1;
      if (take)    rd_off <= rd_off + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timeout_flag <= 1'b0;
      ecc_err      <= 1'b0;
    end else begin
      timeout_flag <= timeout_flag | push_to | pop_to;
      ecc_err      <= ecc_err | flush;
    end
  end

  // R2: the shared tail only ever steps by one slot, except on a flush
  p_tail_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((tl_v != $past(tl_v)) && !$past(flush)) |-> (tl_v == PTR_W'($past(tl_v) + 1'b1)));

  // R4: never more published slots than storage holds
  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PTR_W'(SLOTS));

  // R5: the timeout flag is sticky
  p_sticky_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(timeout_flag) |-> timeout_flag);

  // R6: a released pop returns zero
  p_pop_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_to |-> (rd_data == '0 && !rd_tag));

  // R9: an uncorrectable fault leaves the queue empty
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ecc_err) |-> q_empty);

endmodule

// File: tb/wsq_stream_queue_bench.sv
module wsq_stream_queue_bench;
  import wsq_pkg::*;

  localparam int DATA_W  = 16;
  localparam int SLOTS   = 8;
  localparam int DEPTH   = 4;
  localparam int TIMEOUT = 20;
  localparam int CW      = ham_len($clog2(SLOTS) + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_req = 1'b0, push_tag = 1'b0, pop_req = 1'b0, disc_req = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic push_ack, pop_ack, disc_ack, rd_tag, q_full, q_empty, timeout_flag, ecc_err;
  logic [DATA_W-1:0] rd_data;
  logic [CW-1:0] fault_head = '0, fault_tail = '0;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  wsq_stream_queue #(.DATA_W(DATA_W), .SLOTS(SLOTS), .DEPTH(DEPTH), .TIMEOUT(TIMEOUT))
  u_wsq_stream_queue (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
    .push_tag(push_tag), .push_ack(push_ack), .pop_req(pop_req), .disc_req(disc_req),
    .pop_ack(pop_ack), .disc_ack(disc_ack), .rd_data(rd_data), .rd_tag(rd_tag),
    .q_full(q_full), .q_empty(q_empty), .timeout_flag(timeout_flag), .ecc_err(ecc_err),
    .fault_head(fault_head), .fault_tail(fault_tail));

  task automatic expect_eq(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] wval(input int base, input int i);
    return DATA_W'(base + i);
  endfunction

  function automatic logic wtag(input int i);
    return (i % 3) == 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push_req = 0; pop_req = 0; disc_req = 0;
    fault_head = '0; fault_tail = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_push(input logic [DATA_W-1:0] d, input logic t, output int waited);
    @(negedge clk);
    push_req = 1'b1; push_data = d; push_tag = t; waited = 0;
    while (1) begin
      #4;
      if (push_ack) break;
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    push_req = 1'b0;
  endtask

  task automatic do_pop(output logic [DATA_W-1:0] d, output logic t, output int waited);
    @(negedge clk);
    pop_req = 1'b1; waited = 0;
    while (1) begin
      #4;
      if (pop_ack) begin d = rd_data; t = rd_tag; break; end
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  task automatic push_run(input string req, input int base, input int first, input int n);
    int w;
    for (int i = first; i < first + n; i++) begin
      do_push(wval(base, i), wtag(i), w);
      expect_eq(req, "push wait", w, 0);
    end
  endtask

  task automatic pop_run(input string req, input int base, input int first, input int n);
    logic [DATA_W-1:0] d;
    logic t;
    int w;
    for (int i = first; i < first + n; i++) begin
      do_pop(d, t, w);
      expect_eq(req, "pop data", d, wval(base, i));
      expect_eq(req, "pop tag", t, wtag(i));
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    expect_eq("R1", "empty", q_empty, 1);
    expect_eq("R1", "full", q_full, 0);
    expect_eq("R1", "flags", {timeout_flag, ecc_err}, 0);
    expect_eq("R1", "acks", {push_ack, pop_ack, disc_ack}, 0);
  endtask

  task automatic t_partial_slot();
    logic [DATA_W-1:0] d;
    logic t;
    int w;
    do_reset();
    push_run("R2", 'h100, 0, DEPTH - 1);
    expect_eq("R2", "partial slot empty", q_empty, 1);
    do_pop(d, t, w);
    expect_eq("R6", "pop timeout wait", w, TIMEOUT);
    expect_eq("R6", "pop timeout data", d, 0);
    expect_eq("R6", "pop timeout tag", t, 0);
    expect_eq("R6", "timeout flag", timeout_flag, 1);
    push_run("R2", 'h100, DEPTH - 1, 1);
    #1 expect_eq("R2", "slot published", q_empty, 0);
    pop_run("R3", 'h100, 0, DEPTH);
  endtask

  task automatic t_order();
    do_reset();
    push_run("R3", 'h200, 0, 2 * DEPTH);
    pop_run("R3", 'h200, 0, 2 * DEPTH);
    #1 expect_eq("R3", "drained", q_empty, 1);
    expect_eq("R3", "no timeout", timeout_flag, 0);
  endtask

  task automatic t_full();
    int w;
    do_reset();
    push_run("R4", 'h300, 0, SLOTS * DEPTH);
    #1 expect_eq("R4", "full", q_full, 1);
    do_push('hBEEF, 1'b1, w);
    expect_eq("R5", "push timeout wait", w, TIMEOUT);
    expect_eq("R5", "timeout flag", timeout_flag, 1);
    pop_run("R5", 'h300, 0, SLOTS * DEPTH);
    #1 expect_eq("R5", "dropped word absent", q_empty, 1);
  endtask

  task automatic t_discard();
    do_reset();
    @(negedge clk);
    disc_req = 1'b1;
    #4;
    expect_eq("R7", "empty discard ack", disc_ack, 1);
    expect_eq("R7", "empty discard data", rd_data, 0);
    @(negedge clk);
    disc_req = 1'b0;
    push_run("R7", 'h400, 0, 2 * DEPTH);
    @(negedge clk);
    disc_req = 1'b1;
    #4;
    expect_eq("R7", "discard ack", disc_ack, 1);
    expect_eq("R7", "discard data", rd_data, wval('h400, 0));
    expect_eq("R7", "discard tag", rd_tag, wtag(0));
    @(negedge clk);
    disc_req = 1'b0;
    pop_run("R7", 'h400, 1, 1);
    @(negedge clk);
    pop_req = 1'b1; disc_req = 1'b1;
    #4;
    expect_eq("R7", "pop wins ack", {pop_ack, disc_ack}, 2'b10);
    expect_eq("R7", "pop wins data", rd_data, wval('h400, 2));
    @(negedge clk);
    pop_req = 1'b0;
    #4;
    expect_eq("R7", "discard served later", disc_ack, 1);
    expect_eq("R7", "discard later data", rd_data, wval('h400, 3));
    @(negedge clk);
    disc_req = 1'b0;
    pop_run("R7", 'h400, 4, DEPTH);
  endtask

  task automatic t_single_fault();
    do_reset();
    push_run("R8", 'h500, 0, DEPTH);
    @(negedge clk) fault_tail = CW'(1) << 3;
    @(negedge clk) fault_tail = '0;
    @(negedge clk) fault_head = CW'(1) << 5;
    @(negedge clk) fault_head = '0;
    repeat (2) @(negedge clk);
    expect_eq("R8", "no error", ecc_err, 0);
    expect_eq("R8", "still holds slot", q_empty, 0);
    pop_run("R8", 'h500, 0, DEPTH);
  endtask

  task automatic t_double_fault();
    do_reset();
    push_run("R9", 'h600, 0, 2 * DEPTH);
    @(negedge clk) fault_head = CW'(6);
    @(negedge clk) fault_head = '0;
    repeat (2) @(negedge clk);
    expect_eq("R9", "error flag", ecc_err, 1);
    expect_eq("R9", "flushed", q_empty, 1);
    push_run("R9", 'h700, 0, DEPTH);
    pop_run("R9", 'h700, 0, DEPTH);
    expect_eq("R9", "flag sticky", ecc_err, 1);
  endtask

  task automatic t_overlap();
    do_reset();
    push_run("R10", 'h800, 0, 2 * DEPTH - 1);
    pop_run("R10", 'h800, 0, DEPTH - 1);
    @(negedge clk);
    push_req = 1'b1; push_data = wval('h800, 2 * DEPTH - 1); push_tag = wtag(2 * DEPTH - 1);
    pop_req = 1'b1;
    #4;
    expect_eq("R10", "both acks", {push_ack, pop_ack}, 2'b11);
    expect_eq("R10", "last of slot0", rd_data, wval('h800, DEPTH - 1));
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    #1 expect_eq("R10", "slot1 visible", q_empty, 0);
    pop_run("R10", 'h800, DEPTH, DEPTH);
    #1 expect_eq("R10", "drained", q_empty, 1);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset_state();
    t_partial_slot();
    t_order();
    t_full();
    t_discard();
    t_single_fault();
    t_double_fault();
    t_overlap();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule